// File: doc/BRIEF.md
# Instruction TLB Invalidate-by-ASID Matcher

This block keeps a small, fully associative store of instruction translation entries and runs one maintenance operation on it: removing every cached entry that belongs to a given address-space identifier. Each entry records whether it is valid, whether it comes from the second translation stage, whether it comes from the final lookup level or from a level above it, whether the page is global, and its address-space tag, virtual-machine tag and translation regime.

A command carries a 32-bit operand with the ASID in its low byte, the current virtual-machine tag, a flag that says whether the hypervisor level is enabled, and the target regime. All matching entries are removed in one clock edge, and a done pulse follows in the next cycle. The effect is local to this store, and nothing is broadcast. A fill port and a lookup port load entries and observe them.

Top module: `itlb_asid_purge`

## Requirements
- R1: The ASID used for matching is `cmd_operand[7:0]`. Bits 31:8 have no effect on which entries are cleared.
- R2: An entry with `stage2` set is never cleared by a command.
- R3: A valid stage-1 entry that is not from the final level (`last=0`) is cleared when its ASID matches, whether or not it is global.
- R4: A final-level entry (`last=1`) is cleared only when it is non-global and its ASID matches. Final-level global entries stay valid.
- R5: When `cmd_hyp_en=1`, a cleared entry must also have a VMID equal to `cmd_vmid`. When `cmd_hyp_en=0`, the VMID is not compared.
- R6: Only entries whose regime code equals `cmd_regime` are cleared. The codes are 0 secure kernel (64-bit monitor), 1 secure kernel (32-bit monitor), 2 non-secure kernel, and 3 monitor.
- R7: The clear takes effect at the clock edge that samples `cmd_valid=1`. `done` is high for exactly the following cycle and is low in every cycle that does not follow a command.
- R8: `fill_ready` is low whenever `cmd_valid` is high, and high otherwise. A fill writes entry `fill_idx` and sets it valid at an edge where `fill_valid` and `fill_ready` are both high. A stalled fill that is retried after the command therefore survives the clear.
- R9: `lk_hit` is high when some valid entry has a regime equal to `lk_regime`, a VMID equal to `lk_vmid` (compared only when `lk_hyp_en=1`), and either an ASID equal to `lk_asid` or the global flag set. `lk_idx` gives the lowest such index. The lookup is combinational.
- R10: After reset no entry is valid and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Invalidate-by-ASID command strobe |
| cmd_operand | input | 32 | Command operand, ASID in bits 7:0 |
| cmd_vmid | input | 8 | Current virtual-machine tag |
| cmd_hyp_en | input | 1 | Hypervisor level enabled, so the VMID is compared |
| cmd_regime | input | 2 | Target translation regime code |
| done | output | 1 | Completion pulse, one cycle after the command |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_idx | input | 4 | Entry slot to write |
| fill_stage2 | input | 1 | Entry is from stage 2 |
| fill_last | input | 1 | Entry is from the final lookup level |
| fill_glob | input | 1 | Entry is a global page |
| fill_asid | input | 8 | Entry ASID |
| fill_vmid | input | 8 | Entry VMID |
| fill_regime | input | 2 | Entry regime code |
| lk_asid | input | 8 | Lookup ASID |
| lk_vmid | input | 8 | Lookup VMID |
| lk_hyp_en | input | 1 | Compare the VMID on lookup |
| lk_regime | input | 2 | Lookup regime code |
| lk_hit | output | 1 | Some entry matches the lookup |
| lk_idx | output | 4 | Lowest matching entry index |

## Verification
The bench targets entries that nearly match. These include a global entry above the final level, which a design that looks at the global flag alone would wrongly keep, and a final-level global entry, which a plain ASID compare would wrongly drop. It also covers a stage-2 entry with a matching ASID, an entry with the right ASID in the wrong regime, and a VMID mismatch issued with the hypervisor flag both set and clear. Operands carry random upper bits, so a design that compared more than the low byte would miss entries. A fill collides with a command so that a design that wrote it before the clear, or dropped it, would lose the entry, and `done` is watched so that a missing or stretched pulse shows.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int ASID_W = 8;
    localparam int VMID_W = 8;

    typedef enum logic [1:0] {
        RG_SEC_K64 = 2'd0,
        RG_SEC_K32 = 2'd1,
        RG_NSEC    = 2'd2,
        RG_MON     = 2'd3
    } regime_e;

    typedef struct packed {
        logic              stage2;
        logic              last_lvl;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        regime_e           regime;
    } ent_t;
endpackage

// File: rtl/itlb_inv_match.sv
module itlb_inv_match
    import itlb_pkg::*;
(
    input  logic              vld,
    input  ent_t              ent,
    input  logic [ASID_W-1:0] asid,
    input  logic [VMID_W-1:0] vmid,
    input  logic              hyp_en,
    input  regime_e           regime,
    output logic              kill
);
    logic scope_ok;
    logic vm_ok;
    logic pg_ok;

    always_comb begin
        scope_ok = vld && !ent.stage2 && (ent.regime == regime);
        vm_ok    = !hyp_en || (ent.vmid == vmid);
        pg_ok    = !ent.last_lvl || !ent.glob;
        kill     = scope_ok && vm_ok && pg_ok && (ent.asid == asid);
    end
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]      vld,
    input  ent_t [ENTRIES-1:0]      ent,
    input  logic [ASID_W-1:0]       asid,
    input  logic [VMID_W-1:0]       vmid,
    input  logic                    hyp_en,
    input  regime_e                 regime,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [ENTRIES-1:0] hv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hv[g] = vld[g] && (ent[g].regime == regime)
                    && (!hyp_en || (ent[g].vmid == vmid))
                    && ((ent[g].asid == asid) || ent[g].glob);
    end

    always_comb begin
        hit = |hv;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/itlb_asid_purge.sv
module itlb_asid_purge
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_operand,
    input  logic [VMID_W-1:0] cmd_vmid,
    input  logic              cmd_hyp_en,
    input  logic [1:0]        cmd_regime,
    output logic              done,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fill_stage2,
    input  logic              fill_last,
    input  logic              fill_glob,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [1:0]        fill_regime,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic              lk_hyp_en,
    input  logic [1:0]        lk_regime,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0] vld;
        ent_t [ENTRIES-1:0] ent;
        logic               done;
    } st_t;

    st_t                st_d;
    st_t                st_q;
    logic [ENTRIES-1:0] kill;
    logic               fill_we;
    ent_t               fill_ent;
    logic [ENTRIES-1:0] vld_q;
    ent_t [ENTRIES-1:0] ent_q;
    logic               unused_op_hi;

    assign unused_op_hi = ^cmd_operand[31:ASID_W];
    assign vld_q        = st_q.vld;
    assign ent_q        = st_q.ent;
    assign done         = st_q.done;
    assign fill_ready   = !cmd_valid;
    assign fill_we      = fill_valid && fill_ready;

    always_comb begin
        fill_ent.stage2   = fill_stage2;
        fill_ent.last_lvl = fill_last;
        fill_ent.glob     = fill_glob;
        fill_ent.asid     = fill_asid;
        fill_ent.vmid     = fill_vmid;
        fill_ent.regime   = regime_e'(fill_regime);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        itlb_inv_match u_m (
            .vld    (st_q.vld[g]),
            .ent    (st_q.ent[g]),
            .asid   (cmd_operand[ASID_W-1:0]),
            .vmid   (cmd_vmid),
            .hyp_en (cmd_hyp_en),
            .regime (regime_e'(cmd_regime)),
            .kill   (kill[g])
        );
    end

    itlb_lookup #(.ENTRIES(ENTRIES)) u_lk (
        .vld    (st_q.vld),
        .ent    (st_q.ent),
        .asid   (lk_asid),
        .vmid   (lk_vmid),
        .hyp_en (lk_hyp_en),
        .regime (regime_e'(lk_regime)),
        .hit    (lk_hit),
        .idx    (lk_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = cmd_valid;
        if (cmd_valid) begin
            st_d.vld = st_q.vld & ~kill;
        end
        if (fill_we) begin
            st_d.vld[fill_idx] = 1'b1;
            st_d.ent[fill_idx] = fill_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/itlb_asid_purge_chk.sv
module itlb_asid_purge_chk
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               fill_valid,
    input logic               fill_ready,
    input logic               done,
    input logic [ENTRIES-1:0] vld,
    input ent_t [ENTRIES-1:0] ent
);
    logic [ENTRIES-1:0] s2_live;
    logic [ENTRIES-1:0] gfin_live;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
        assign s2_live[g]   = vld[g] && ent[g].stage2;
        assign gfin_live[g] = vld[g] && ent[g].last_lvl && ent[g].glob;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);

    // R8
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !fill_ready);

    // R2
    stage2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (($past(s2_live) & ~vld) == '0));

    // R4
    global_final_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (($past(gfin_live) & ~vld) == '0));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !fill_valid) |=> $stable(vld));
endmodule

bind itlb_asid_purge itlb_asid_purge_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .done       (done),
    .vld        (vld_q),
    .ent        (ent_q)
);

// File: tb/sim_itlb_asid_purge.sv
module sim_itlb_asid_purge;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_operand = '0;
    logic [7:0]  cmd_vmid = '0;
    logic        cmd_hyp_en = 1'b0;
    logic [1:0]  cmd_regime = '0;
    logic        done;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [3:0]  fill_idx = '0;
    logic        fill_stage2 = 1'b0;
    logic        fill_last = 1'b0;
    logic        fill_glob = 1'b0;
    logic [7:0]  fill_asid = '0;
    logic [7:0]  fill_vmid = '0;
    logic [1:0]  fill_regime = '0;
    logic [7:0]  lk_asid = '0;
    logic [7:0]  lk_vmid = '0;
    logic        lk_hyp_en = 1'b0;
    logic [1:0]  lk_regime = '0;
    logic        lk_hit;
    logic [3:0]  lk_idx;

    int checks = 0;
    int fails  = 0;

    bit       m_v [N];
    bit       m_s2[N];
    bit       m_l [N];
    bit       m_g [N];
    bit [7:0] m_a [N];
    bit [7:0] m_vm[N];
    bit [1:0] m_rg[N];

    always #5 clk = ~clk;

    itlb_asid_purge u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_kill(int i, bit [31:0] op, bit [7:0] vm, bit h, bit [1:0] rg);
        return m_v[i] && !m_s2[i] && (m_rg[i] == rg) && (m_a[i] == op[7:0])
            && (!m_l[i] || !m_g[i]) && (!h || (m_vm[i] == vm));
    endfunction

    function automatic int exp_lookup(bit [7:0] a, bit [7:0] vm, bit h, bit [1:0] rg);
        for (int j = 0; j < N; j++) begin
            if (m_v[j] && (m_rg[j] == rg) && (!h || (m_vm[j] == vm))
                && ((m_a[j] == a) || m_g[j])) return j;
        end
        return -1;
    endfunction

    task automatic model_cmd(bit [31:0] op, bit [7:0] vm, bit h, bit [1:0] rg);
        bit k[N];
        for (int i = 0; i < N; i++) k[i] = exp_kill(i, op, vm, h, rg);
        for (int i = 0; i < N; i++) if (k[i]) m_v[i] = 1'b0;
    endtask

    task automatic model_fill();
        m_v[fill_idx]  = 1'b1;
        m_s2[fill_idx] = fill_stage2;
        m_l[fill_idx]  = fill_last;
        m_g[fill_idx]  = fill_glob;
        m_a[fill_idx]  = fill_asid;
        m_vm[fill_idx] = fill_vmid;
        m_rg[fill_idx] = fill_regime;
    endtask

    task automatic set_fill(int idx, bit s2, bit l, bit g, bit [7:0] a, bit [7:0] vm, bit [1:0] rg);
        fill_idx = idx[3:0]; fill_stage2 = s2; fill_last = l; fill_glob = g;
        fill_asid = a; fill_vmid = vm; fill_regime = rg; fill_valid = 1'b1;
    endtask

    task automatic do_fill(int idx, bit s2, bit l, bit g, bit [7:0] a, bit [7:0] vm, bit [1:0] rg);
        @(negedge clk);
        set_fill(idx, s2, l, g, a, vm, rg);
        #1 chk(fill_ready == 1'b1, "R8", "fill_ready idle", fill_ready, 1);
        @(posedge clk);
        model_fill();
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_cmd(bit [31:0] op, bit [7:0] vm, bit h, bit [1:0] rg, bit with_fill);
        @(negedge clk);
        cmd_operand = op; cmd_vmid = vm; cmd_hyp_en = h; cmd_regime = rg; cmd_valid = 1'b1;
        if (with_fill) begin
            #1 chk(fill_ready == 1'b0, "R8", "fill_ready during cmd", fill_ready, 0);
        end
        @(posedge clk);
        model_cmd(op, vm, h, rg);
        @(negedge clk);
        chk(done == 1'b1, "R7", "done after cmd", done, 1);
        cmd_valid = 1'b0;
        if (with_fill) begin
            #1 chk(fill_ready == 1'b1, "R8", "fill_ready after cmd", fill_ready, 1);
            @(posedge clk);
            model_fill();
            @(negedge clk);
            fill_valid = 1'b0;
        end else begin
            @(negedge clk);
        end
        chk(done == 1'b0, "R7", "done falls", done, 0);
    endtask

    task automatic probe(input string req);
        for (int i = 0; i < N; i++) begin
            int e;
            lk_asid = m_a[i]; lk_vmid = m_vm[i]; lk_hyp_en = i[0]; lk_regime = m_rg[i];
            #1;
            e = exp_lookup(m_a[i], m_vm[i], i[0], m_rg[i]);
            chk(lk_hit == (e >= 0), req, "lk_hit", lk_hit, e >= 0);
            if (e >= 0) chk(int'(lk_idx) == e, req, "lk_idx", lk_idx, e);
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: empty after reset
        chk(done == 1'b0, "R10", "done at reset", done, 0);
        probe("R10");

        // Directed: near-miss set around ASID 5, regime 2, VMID 1
        do_fill(0, 1, 1, 0, 8'd5, 8'd1, 2'd2);  // stage 2
        do_fill(1, 0, 0, 1, 8'd5, 8'd1, 2'd2);  // upper level, global
        do_fill(2, 0, 1, 1, 8'd5, 8'd1, 2'd2);  // final, global
        do_fill(3, 0, 1, 0, 8'd5, 8'd1, 2'd2);  // final, non-global
        do_fill(4, 0, 1, 0, 8'd5, 8'd1, 2'd0);  // other regime
        do_fill(5, 0, 1, 0, 8'd6, 8'd1, 2'd2);  // other ASID
        do_fill(6, 0, 1, 0, 8'd5, 8'd2, 2'd2);  // other VMID
        do_fill(7, 0, 0, 0, 8'd5, 8'd1, 2'd2);  // upper level, non-global
        probe("R9");
        // R1 R2 R3 R4 R6: upper bits set in operand
        do_cmd(32'hABCDEF05, 8'd1, 1'b1, 2'd2, 1'b0);
        chk(m_v[1] == 0 && m_v[2] == 1 && m_v[0] == 1, "R3", "model sanity", m_v[1], 0);
        probe("R1 R2 R3 R4 R6");
        // R5: VMID ignored when hypervisor level is off
        do_cmd(32'h00000005, 8'd9, 1'b0, 2'd2, 1'b0);
        probe("R5");
        // R8: colliding fill reuses a slot in the target scope
        @(negedge clk);
        set_fill(3, 0, 1, 0, 8'd5, 8'd1, 2'd2);
        do_cmd(32'h00000005, 8'd1, 1'b1, 2'd2, 1'b1);
        probe("R8");

        // Random mix
        for (int r = 0; r < 80; r++) begin
            for (int f = 0; f < 3; f++) begin
                do_fill($urandom_range(0, N - 1), ($urandom_range(0, 3) == 0),
                        $urandom_range(0, 1), $urandom_range(0, 1),
                        8'($urandom_range(0, 3)), 8'($urandom_range(0, 1)),
                        2'($urandom_range(0, 3)));
            end
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                set_fill($urandom_range(0, N - 1), 0, $urandom_range(0, 1), 0,
                         8'($urandom_range(0, 3)), 8'($urandom_range(0, 1)),
                         2'($urandom_range(0, 3)));
                do_cmd({24'($urandom), 8'($urandom_range(0, 3))}, 8'($urandom_range(0, 1)),
                       $urandom_range(0, 1), 2'($urandom_range(0, 3)), 1'b1);
            end else begin
                do_cmd({24'($urandom), 8'($urandom_range(0, 3))}, 8'($urandom_range(0, 1)),
                       $urandom_range(0, 1), 2'($urandom_range(0, 3)), 1'b0);
            end
            probe("R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule